// File: doc/BRIEF.md
# SDRAM Gapless Read Burst Sequencer

This block sits on the controller side of an SDRAM read path, where the target rows are already open. It takes read requests one at a time through a valid/ready handshake. Each request names a bank, a column and an identifier. For each accepted request the block drives one READ command, and it drives NOP in every other cycle. Each READ produces a four-word burst.

The block spaces READ commands exactly one burst length apart. Each following READ therefore reaches the memory CAS-latency-minus-one cycles before the last word of the current burst, and bursts to any bank join on the data bus with no idle cycle between them. Returning words pass through a tag delay line whose depth equals the selected CAS latency. They leave the block on a valid-only stream, and each word carries its request identifier and its beat number.

On the request side, `req_ready` is the only source of back-pressure. The producer holds `req_valid` and the request fields steady until it sees `req_ready` high at a clock edge. The read stream cannot be stalled, because the memory cannot pause a burst. The consumer must take every word that is marked by `rd_valid`.

Top module: `sdram_rd_seq`

## Requirements
- R1: While `rst_n` is low, the command outputs hold NOP, `cmd_dqm` is 1, `rd_valid` is 0 and `req_ready` is 1.
- R2: A handshake (`req_valid` and `req_ready` both high at an edge) puts READ on the command pins for the next cycle only. READ is encoded CS_n=0, RAS_n=1, CAS_n=0, WE_n=1. During that cycle `cmd_ba` and `cmd_addr` carry the accepted bank and column. Every other cycle carries NOP, encoded CS_n=0, RAS_n=1, CAS_n=1, WE_n=1.
- R3: After a handshake, `req_ready` stays low for three cycles. With requests offered back to back, READ commands are exactly four cycles apart, with three NOPs between them.
- R4: `cas_lat_sel`=0 selects latency 2 and `cas_lat_sel`=1 selects latency 3. Let READ be on the command pins in cycle t with latency L. The `mem_dq_in` values of cycles t+L to t+L+3 then appear on `rd_data` in cycles t+L+1 to t+L+4. In those cycles `rd_valid` is high, `rd_beat` is 0, 1, 2, 3, and `rd_id` is the request's identifier.
- R5: With requests offered back to back, `rd_valid` stays high without a gap across all the bursts, at both latencies.
- R6: Consecutive requests to the same bank and to different banks are accepted with the same spacing.
- R7: From the first clock after reset, `cmd_dqm` is held at 0.
- R8: When no request is offered, the command pins carry NOP. `rd_valid` falls in the cycle after the last beat of the final burst.
- R9: The latency setting is taken only while no burst is in flight. A change of `cas_lat_sel` during a burst does not affect bursts already accepted. It takes effect once the pipeline has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat_sel | input | 1 | 0 selects latency 2, 1 selects latency 3 |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request is accepted at this edge if valid |
| req_bank | input | BANK_W | Bank of the request |
| req_col | input | COL_W | Column of the burst's first word |
| req_id | input | ID_W | Identifier returned with the data |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BANK_W | Bank address |
| cmd_addr | output | COL_W | Column address |
| cmd_dqm | output | 1 | Data mask, held low after reset |
| mem_dq_in | input | DATA_W | Read data from the memory |
| rd_valid | output | 1 | Captured word valid |
| rd_data | output | DATA_W | Captured word |
| rd_id | output | ID_W | Identifier of the word's request |
| rd_beat | output | 2 | Beat index within the burst |

## Verification
The hardest case to reach from the ports is a latency change that arrives while words are still in flight. To produce it, the bench accepts two back-to-back requests at latency 2 and flips `cas_lat_sel` right after the first handshake. It then requires both bursts to keep latency-2 timing, and requires the next burst, sent after the pipeline drains, to use latency 3. A memory model drives a different value on `mem_dq_in` in every cycle. With that, a word captured one cycle early or late shows up as a data mismatch, and a beat that is dropped shows up as a break in the seamless stream.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);
  localparam int LAT_SHORT = 2;
  localparam int LAT_LONG  = 3;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_cmd_t;

  localparam sdr_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_cmd_t CMD_READ = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};

endpackage

// File: rtl/sdram_rd_issue.sv
module sdram_rd_issue
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [ID_W-1:0]   req_id,
  output sdr_cmd_t          cmd,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [COL_W-1:0]  cmd_addr,
  output logic              cmd_dqm,
  output logic              st_valid,
  output logic [ID_W-1:0]   st_id,
  output logic [BEAT_W-1:0] st_beat
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic accept;

  // A new READ may go out while the beat stream shows its final beat,
  // which puts command edges exactly one burst length apart.
  assign req_ready = !st_valid || (st_beat == LAST_BEAT);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd      <= CMD_NOP;
      cmd_ba   <= '0;
      cmd_addr <= '0;
      cmd_dqm  <= 1'b1;
      st_valid <= 1'b0;
      st_id    <= '0;
      st_beat  <= '0;
    end else begin
      cmd_dqm <= 1'b0;
      cmd     <= CMD_NOP;
      if (accept) begin
        cmd      <= CMD_READ;
        cmd_ba   <= req_bank;
        cmd_addr <= req_col;
        st_valid <= 1'b1;
        st_id    <= req_id;
        st_beat  <= '0;
      end else if (st_valid) begin
        if (st_beat == LAST_BEAT) begin
          st_valid <= 1'b0;
        end
        st_beat <= st_beat + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdram_rd_tagpipe.sv
module sdram_rd_tagpipe
  import sdram_rd_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat_long,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic             busy
);

  localparam int DEPTH = LAT_LONG;

  logic [DEPTH-1:0] v_q;
  logic [TAG_W-1:0] t_q [DEPTH];
  int               tap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int s = 0; s < DEPTH; s++) t_q[s] <= '0;
    end else begin
      v_q    <= {v_q[DEPTH-2:0], in_valid};
      t_q[0] <= in_tag;
      for (int s = 1; s < DEPTH; s++) t_q[s] <= t_q[s-1];
    end
  end

  // The tap sits latency-1 stages down the line, so a tag lines up with
  // the data word that the memory drives in the same cycle.
  always_comb begin
    tap  = lat_long ? (LAT_LONG - 1) : (LAT_SHORT - 1);
    busy = 1'b0;
    for (int s = 0; s < DEPTH; s++) begin
      if (s <= tap && v_q[s]) busy = 1'b1;
    end
  end

  assign out_valid = v_q[tap];
  assign out_tag   = t_q[tap];

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_valid,
  input  logic [TAG_W-1:0]  tap_tag,
  input  logic [DATA_W-1:0] dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_tag   <= '0;
    end else begin
      rd_valid <= tap_valid;
      if (tap_valid) begin
        rd_data <= dq;
        rd_tag  <= tap_tag;
      end
    end
  end

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int ID_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_lat_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [ID_W-1:0]   req_id,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [COL_W-1:0]  cmd_addr,
  output logic              cmd_dqm,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ID_W-1:0]   rd_id,
  output logic [1:0]        rd_beat
);

  localparam int TAG_W = ID_W + BEAT_W;

  sdr_cmd_t          cmd;
  logic              st_valid;
  logic [ID_W-1:0]   st_id;
  logic [BEAT_W-1:0] st_beat;
  logic              cl_q;
  logic              idle;
  logic              pipe_busy;
  logic              tap_valid;
  logic [TAG_W-1:0]  tap_tag;
  logic [TAG_W-1:0]  rd_tag;

  sdram_rd_issue #(.BANK_W(BANK_W), .COL_W(COL_W), .ID_W(ID_W)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_id(req_id),
    .cmd(cmd), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .cmd_dqm(cmd_dqm),
    .st_valid(st_valid), .st_id(st_id), .st_beat(st_beat)
  );

  // Latency is frozen while any beat is scheduled or travelling.
  assign idle = !st_valid && !pipe_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) cl_q <= 1'b0;
    else if (idle) cl_q <= cas_lat_sel;
  end

  sdram_rd_tagpipe #(.TAG_W(TAG_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .lat_long(cl_q),
    .in_valid(st_valid), .in_tag({st_id, st_beat}),
    .out_valid(tap_valid), .out_tag(tap_tag), .busy(pipe_busy)
  );

  sdram_rd_capture #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .tap_valid(tap_valid), .tap_tag(tap_tag), .dq(mem_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag)
  );

  assign cmd_cs_n  = cmd.cs_n;
  assign cmd_ras_n = cmd.ras_n;
  assign cmd_cas_n = cmd.cas_n;
  assign cmd_we_n  = cmd.we_n;
  assign rd_id     = rd_tag[TAG_W-1:BEAT_W];
  assign rd_beat   = rd_tag[BEAT_W-1:0];

endmodule

// File: rtl/sdram_rd_seq_chk.sv
module sdram_rd_seq_chk #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic [COL_W-1:0]  req_col,
  input logic              cmd_cs_n,
  input logic              cmd_ras_n,
  input logic              cmd_cas_n,
  input logic              cmd_we_n,
  input logic [BANK_W-1:0] cmd_ba,
  input logic [COL_W-1:0]  cmd_addr,
  input logic              cmd_dqm,
  input logic              rd_valid,
  input logic [ID_W-1:0]   rd_id,
  input logic [1:0]        rd_beat,
  input logic              idle,
  input logic              cl_q
);

  logic is_read;
  assign is_read = !cmd_cs_n && cmd_ras_n && !cmd_cas_n && cmd_we_n;

  // R2
  read_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |-> ($past(req_valid && req_ready) && cmd_ba == $past(req_bank)
                 && cmd_addr == $past(req_col)));

  // R3
  read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |-> (!$past(is_read) && !$past(is_read, 2) && !$past(is_read, 3)));

  // R4
  beat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_beat != 2'd3) |=> (rd_valid && rd_beat == $past(rd_beat) + 2'd1
                                       && $stable(rd_id)));

  // R7
  mask_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !cmd_dqm);

  // R8
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> !is_read);

  // R9
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(idle) && $past(rst_n)) |-> $stable(cl_q));

endmodule

bind sdram_rd_seq sdram_rd_seq_chk #(.BANK_W(BANK_W), .COL_W(COL_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bank(req_bank), .req_col(req_col),
  .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
  .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .cmd_dqm(cmd_dqm),
  .rd_valid(rd_valid), .rd_id(rd_id), .rd_beat(rd_beat),
  .idle(idle), .cl_q(cl_q)
);

// File: tb/tb_sdram_rd_seq.sv
module tb_sdram_rd_seq;

  localparam int BANK_W = 2;
  localparam int COL_W  = 9;
  localparam int ID_W   = 4;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cas_lat_sel = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [BANK_W-1:0] req_bank = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [ID_W-1:0]   req_id = '0;
  logic              cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [BANK_W-1:0] cmd_ba;
  logic [COL_W-1:0]  cmd_addr;
  logic              cmd_dqm;
  logic [DATA_W-1:0] mem_dq_in;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [ID_W-1:0]   rd_id;
  logic [1:0]        rd_beat;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DATA_W-1:0] dq_of(int c);
    return DATA_W'(c * 7 + 3);
  endfunction

  assign mem_dq_in = dq_of(cyc);

  sdram_rd_seq #(.BANK_W(BANK_W), .COL_W(COL_W), .ID_W(ID_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .cas_lat_sel(cas_lat_sel),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_id(req_id),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .cmd_dqm(cmd_dqm),
    .mem_dq_in(mem_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_id(rd_id), .rd_beat(rd_beat)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard state shared by the monitor and the scenario tasks.
  logic [BANK_W-1:0] sent_bank [64];
  logic [COL_W-1:0]  sent_col  [64];
  logic [ID_W-1:0]   sent_id   [64];
  int n_sent = 0;
  int n_reads = 0;
  int exp_cl = 2;
  string cur_tag = "R4";
  bit mon_en = 0;
  bit b2b = 0;
  int prev_read = -1;
  bit exp_v [64];
  logic [DATA_W-1:0] exp_d [64];
  logic [ID_W-1:0]   exp_id [64];
  logic [1:0]        exp_beat [64];
  int v_cnt = 0;
  int v_first = -1;
  int v_last = -1;

  initial for (int k = 0; k < 64; k++) exp_v[k] = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      int idx;
      bit is_rd;
      bit is_nop;
      idx = cyc % 64;
      check(cmd_dqm == 1'b0, "R7", "dqm", int'(cmd_dqm), 0);
      if (exp_v[idx]) begin
        check(rd_valid == 1'b1, cur_tag, "rd_valid", int'(rd_valid), 1);
        check(rd_data == exp_d[idx], cur_tag, "rd_data", int'(rd_data), int'(exp_d[idx]));
        check(rd_id == exp_id[idx], cur_tag, "rd_id", int'(rd_id), int'(exp_id[idx]));
        check(rd_beat == exp_beat[idx], cur_tag, "rd_beat", int'(rd_beat), int'(exp_beat[idx]));
      end else begin
        check(rd_valid == 1'b0, "R8", "rd_valid idle", int'(rd_valid), 0);
      end
      exp_v[idx] = 0;
      if (rd_valid) begin
        v_cnt++;
        if (v_first < 0) v_first = cyc;
        v_last = cyc;
      end
      is_rd  = !cmd_cs_n && cmd_ras_n && !cmd_cas_n && cmd_we_n;
      is_nop = !cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n;
      check(is_rd || is_nop, "R2", "cmd encoding",
            int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}), 5);
      if (is_rd) begin
        check(cmd_ba == sent_bank[n_reads], "R2", "cmd_ba", int'(cmd_ba), int'(sent_bank[n_reads]));
        check(cmd_addr == sent_col[n_reads], "R2", "cmd_addr", int'(cmd_addr), int'(sent_col[n_reads]));
        if (b2b && prev_read >= 0)
          check(cyc - prev_read == 4, "R3", "read spacing", cyc - prev_read, 4);
        prev_read = cyc;
        for (int b = 0; b < 4; b++) begin
          int j;
          j = (cyc + exp_cl + b + 1) % 64;
          exp_v[j]    = 1;
          exp_d[j]    = dq_of(cyc + exp_cl + b);
          exp_id[j]   = sent_id[n_reads];
          exp_beat[j] = 2'(b);
        end
        n_reads++;
      end
    end
  end

  task automatic send(input logic [BANK_W-1:0] bank);
    sent_bank[n_sent] = bank;
    sent_col[n_sent]  = COL_W'((n_sent * 37 + 5) % 512);
    sent_id[n_sent]   = ID_W'(n_sent);
    req_bank  = bank;
    req_col   = sent_col[n_sent];
    req_id    = sent_id[n_sent];
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    n_sent++;
  endtask

  task automatic drain_and_check_idle(input string req);
    req_valid = 1'b0;
    repeat (12) @(negedge clk);
    check(cmd_cs_n == 0 && cmd_ras_n == 1 && cmd_cas_n == 1 && cmd_we_n == 1, req,
          "idle command NOP", int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}), 7);
    check(rd_valid == 1'b0, req, "idle rd_valid", int'(rd_valid), 0);
    check(req_ready == 1'b1, req, "idle req_ready", int'(req_ready), 1);
  endtask

  task automatic set_lat(input int lat);
    cas_lat_sel = (lat == 3);
    exp_cl = lat;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(cmd_cs_n == 0 && cmd_ras_n == 1 && cmd_cas_n == 1 && cmd_we_n == 1, "R1",
          "reset cmd", int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}), 7);
    check(cmd_dqm == 1'b1, "R1", "reset dqm", int'(cmd_dqm), 1);
    check(rd_valid == 1'b0, "R1", "reset rd_valid", int'(rd_valid), 0);
    check(req_ready == 1'b1, "R1", "reset req_ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1;
  endtask

  task automatic t_single(input int lat);
    cur_tag = "R4";
    b2b = 0;
    set_lat(lat);
    send(2'd1);
    check(req_ready == 1'b0, "R3", "ready low after accept", int'(req_ready), 0);
    @(negedge clk);
    check(req_ready == 1'b0, "R3", "ready low 2nd cycle", int'(req_ready), 0);
    drain_and_check_idle("R8");
  endtask

  task automatic t_stream(input int lat, input int n, input bit same_bank, input string tag);
    cur_tag = tag;
    set_lat(lat);
    b2b = 1;
    prev_read = -1;
    v_cnt = 0;
    v_first = -1;
    v_last = -1;
    for (int k = 0; k < n; k++) send(same_bank ? 2'd2 : BANK_W'(k));
    drain_and_check_idle("R8");
    check(v_cnt == 4 * n, tag, "stream words", v_cnt, 4 * n);
    check(v_last - v_first + 1 == 4 * n, "R5", "stream without gap", v_last - v_first + 1, 4 * n);
    b2b = 0;
  endtask

  task automatic t_lat_change;
    cur_tag = "R9";
    set_lat(2);
    b2b = 1;
    prev_read = -1;
    send(2'd0);
    cas_lat_sel = 1'b1;
    send(2'd3);
    drain_and_check_idle("R9");
    b2b = 0;
    exp_cl = 3;
    send(2'd1);
    drain_and_check_idle("R9");
    set_lat(2);
  endtask

  initial begin
    t_reset();
    t_single(2);
    t_single(3);
    t_stream(2, 3, 1'b0, "R6");
    t_stream(3, 3, 1'b0, "R5");
    t_stream(2, 4, 1'b1, "R6");
    t_stream(3, 2, 1'b1, "R5");
    t_lat_change();
    check(n_reads == n_sent, "R2", "read count", n_reads, n_sent);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule